// File: doc/BRIEF.md
# Two-Pass Keyed Record Pairing Sorter

This block pairs the records of two groups that share a small integer key, in time linear in the number of records. In the first pass it accepts Group 1 records, each a key and a data word, and files each record into the bin chosen by its key. Each bin is a linked list held in a record store, and a key-indexed head table points at the newest record of each list. In the second pass, each Group 2 key presented on the query port returns every stored Group 1 record with that key, one per clock cycle, on an output stream that marks its final beat.

Bins are emptied in one cycle by moving to a new event number rather than by sweeping the head table. Each head entry carries the event number that was current when it was written, and an entry is live only while that number is current. A background scrubber walks the head table one key per cycle and kills entries from earlier events. This stops an old entry from coming back to life when the narrow event counter wraps. The sorter can therefore take one event after another with a single clear strobe between them.

Top module: `keyed_bin_sorter`

## Requirements
- R1: After reset, `qry_ready` is 1, `out_valid` is 0 and `overflow` is 0.
- R2: A query returns each stored record with the queried key exactly once, newest first (the reverse of push order), and returns no record of any other key.
- R3: The first beat of a response appears in the cycle after the query is accepted. Later beats follow on consecutive cycles with `out_valid` held high, and `out_last` is 1 on the final beat only.
- R4: A query for a key with no stored records produces exactly one beat with `out_valid`, `out_empty` and `out_last` all 1.
- R5: The first accepted query starts pass 2. From then until the next clear, pushes are ignored, and so is a push in the same cycle as an accepted query.
- R6: A one-cycle `flush` pulse empties every bin from the next cycle on. It also returns the block to pass 1, resets the record count and aborts any response in progress. A push or query in the flush cycle is ignored.
- R7: The record store holds `REC_DEPTH` records. A push while it is full is dropped and sets `overflow`, which stays 1 until the next flush.
- R8: The event counter may wrap. A record filed before a clear never reappears after a later clear, provided that no window of 2^KEY_W cycles contains 2^EPOCH_W or more clears.
- R9: `qry_ready` is 1 only while no response is in progress. A query presented while it is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | One-cycle clear of all bins, starts a new event |
| ins_valid | input | 1 | Group 1 record present |
| ins_key | input | KEY_W | Key of the Group 1 record |
| ins_data | input | DATA_W | Data word of the Group 1 record |
| qry_valid | input | 1 | Group 2 key present |
| qry_key | input | KEY_W | Key to look up |
| qry_ready | output | 1 | Query accepted when high together with qry_valid |
| out_valid | output | 1 | Response beat present |
| out_data | output | DATA_W | Matching record data, zero on an empty beat |
| out_last | output | 1 | Final beat of the response |
| out_empty | output | 1 | Beat means the key had no records |
| overflow | output | 1 | Sticky: a push was dropped because the store was full |

## Verification
The bench builds the sorter with 3-bit keys, 8-bit data, an 8-entry record store and a 2-bit event counter. The small store lets a ninth push hit the full condition within a few cycles. The 2-bit counter comes back to its starting value after four clears, so a stale bin would alias quickly if the scrubber failed to kill it. With eight keys the scrubber laps the head table in eight cycles, so the test can space its clears to respect the rule in R8 and still expose any missing invalidation.

// File: rtl/ks_pkg.sv
package ks_pkg;
    // Response engine state of the sorter.
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,   // ready for a new query
        MODE_WALK = 2'd1,   // emitting records of one bin
        MODE_MISS = 2'd2    // emitting the single empty beat
    } walk_mode_e;
endpackage

// File: rtl/ks_head_table.sv
// Key-indexed table of list heads. Each entry is tagged with the event
// number current when it was written; a background scrubber kills
// entries whose tag is no longer current so a wrapping counter cannot
// revive them.
module ks_head_table #(
    parameter int KEY_W   = 4,
    parameter int PTR_W   = 5,
    parameter int EPOCH_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EPOCH_W-1:0] epoch,
    input  logic               wr_en,
    input  logic [KEY_W-1:0]   wr_key,
    input  logic [PTR_W-1:0]   wr_ptr,
    input  logic [KEY_W-1:0]   key_a,
    output logic               hit_a,
    output logic [PTR_W-1:0]   ptr_a,
    input  logic [KEY_W-1:0]   key_b,
    output logic               hit_b,
    output logic [PTR_W-1:0]   ptr_b
);
    localparam int NKEY = 1 << KEY_W;

    typedef struct packed {
        logic               live;
        logic [EPOCH_W-1:0] tag;
        logic [PTR_W-1:0]   ptr;
    } head_t;

    head_t            tbl_q [NKEY];
    logic [KEY_W-1:0] scrub_q, scrub_d;
    logic             scrub_kill;

    always_comb begin
        scrub_d    = scrub_q + 1'b1;
        scrub_kill = tbl_q[scrub_q].live && (tbl_q[scrub_q].tag != epoch)
                     && !(wr_en && (wr_key == scrub_q));
        hit_a = tbl_q[key_a].live && (tbl_q[key_a].tag == epoch);
        ptr_a = tbl_q[key_a].ptr;
        hit_b = tbl_q[key_b].live && (tbl_q[key_b].tag == epoch);
        ptr_b = tbl_q[key_b].ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scrub_q <= '0;
            for (int i = 0; i < NKEY; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            scrub_q <= scrub_d;
            if (scrub_kill) begin
                tbl_q[scrub_q].live <= 1'b0;
            end
            if (wr_en) begin
                tbl_q[wr_key] <= '{live: 1'b1, tag: epoch, ptr: wr_ptr};
            end
        end
    end
endmodule

// File: rtl/ks_record_store.sv
// Record store: data word plus link to the previous record of the same key.
module ks_record_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_link,
    input  logic [PTR_W-1:0]  wr_next,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_link,
    output logic [PTR_W-1:0]  rd_next
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              link;
        logic [PTR_W-1:0]  next;
    } rec_t;

    rec_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= '{data: wr_data, link: wr_link, next: wr_next};
        end
    end

    always_comb begin
        rd_data = mem_q[rd_addr].data;
        rd_link = mem_q[rd_addr].link;
        rd_next = mem_q[rd_addr].next;
    end
endmodule

// File: rtl/keyed_bin_sorter.sv
module keyed_bin_sorter #(
    parameter int KEY_W     = 4,
    parameter int DATA_W    = 16,
    parameter int REC_DEPTH = 32,
    parameter int EPOCH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              ins_valid,
    input  logic [KEY_W-1:0]  ins_key,
    input  logic [DATA_W-1:0] ins_data,
    input  logic              qry_valid,
    input  logic [KEY_W-1:0]  qry_key,
    output logic              qry_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              out_empty,
    output logic              overflow
);
    import ks_pkg::*;

    localparam int PTR_W = (REC_DEPTH > 1) ? $clog2(REC_DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        walk_mode_e         mode;
        logic [PTR_W-1:0]   cursor;
        logic               pass2;
        logic               ovf;
        logic [CNT_W-1:0]   fill;
        logic [EPOCH_W-1:0] epoch;
    } state_t;

    state_t st_q, st_d;

    logic              hit_a, hit_b;
    logic [PTR_W-1:0]  ptr_a, ptr_b;
    logic [DATA_W-1:0] rec_data;
    logic              rec_link;
    logic [PTR_W-1:0]  rec_next;
    logic              q_take, p_take, full, store;

    ks_head_table #(
        .KEY_W(KEY_W), .PTR_W(PTR_W), .EPOCH_W(EPOCH_W)
    ) u_heads (
        .clk    (clk),
        .rst_n  (rst_n),
        .epoch  (st_q.epoch),
        .wr_en  (store),
        .wr_key (ins_key),
        .wr_ptr (st_q.fill[PTR_W-1:0]),
        .key_a  (ins_key),
        .hit_a  (hit_a),
        .ptr_a  (ptr_a),
        .key_b  (qry_key),
        .hit_b  (hit_b),
        .ptr_b  (ptr_b)
    );

    ks_record_store #(
        .DATA_W(DATA_W), .DEPTH(REC_DEPTH), .PTR_W(PTR_W)
    ) u_recs (
        .clk     (clk),
        .wr_en   (store),
        .wr_addr (st_q.fill[PTR_W-1:0]),
        .wr_data (ins_data),
        .wr_link (hit_a),
        .wr_next (ptr_a),
        .rd_addr (st_q.cursor),
        .rd_data (rec_data),
        .rd_link (rec_link),
        .rd_next (rec_next)
    );

    always_comb begin
        q_take = qry_valid && (st_q.mode == MODE_IDLE) && !flush;
        p_take = ins_valid && !flush && !st_q.pass2 && !q_take;
        full   = (st_q.fill == CNT_W'(REC_DEPTH));
        store  = p_take && !full;

        st_d = st_q;
        unique case (st_q.mode)
            MODE_IDLE: begin
                if (q_take) begin
                    st_d.pass2  = 1'b1;
                    st_d.cursor = ptr_b;
                    st_d.mode   = hit_b ? MODE_WALK : MODE_MISS;
                end
            end
            MODE_WALK: begin
                if (rec_link) begin
                    st_d.cursor = rec_next;
                end else begin
                    st_d.mode = MODE_IDLE;
                end
            end
            MODE_MISS: st_d.mode = MODE_IDLE;
            default:   st_d.mode = MODE_IDLE;
        endcase

        if (store) begin
            st_d.fill = st_q.fill + 1'b1;
        end
        if (p_take && full) begin
            st_d.ovf = 1'b1;
        end

        if (flush) begin
            st_d.mode  = MODE_IDLE;
            st_d.pass2 = 1'b0;
            st_d.ovf   = 1'b0;
            st_d.fill  = '0;
            st_d.epoch = st_q.epoch + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_IDLE, cursor: '0, pass2: 1'b0, ovf: 1'b0,
                      fill: '0, epoch: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        qry_ready = (st_q.mode == MODE_IDLE);
        out_valid = (st_q.mode != MODE_IDLE);
        out_empty = (st_q.mode == MODE_MISS);
        out_last  = (st_q.mode == MODE_MISS) || ((st_q.mode == MODE_WALK) && !rec_link);
        out_data  = (st_q.mode == MODE_WALK) ? rec_data : '0;
        overflow  = st_q.ovf;
    end
endmodule

// File: rtl/ks_chk.sv
module ks_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic qry_valid,
    input logic qry_ready,
    input logic out_valid,
    input logic out_last,
    input logic out_empty,
    input logic overflow
);
    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qry_ready |-> !out_valid);

    // R4
    empty_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_empty |-> (out_valid && out_last));

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (qry_ready && !overflow && !out_valid));

    // R3
    accept_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (qry_valid && qry_ready && !flush) |=> out_valid);

    // R3
    stream_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last && !flush) |=> out_valid);
endmodule

bind keyed_bin_sorter ks_chk u_ks_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .qry_valid (qry_valid),
    .qry_ready (qry_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_empty (out_empty),
    .overflow  (overflow)
);

// File: tb/tb_keyed_bin_sorter.sv
`timescale 1ns/1ps
module tb_keyed_bin_sorter;
    localparam int KW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int EW = 2;
    localparam int NVEC = 11;

    // {op(1: query, 0: push), key(3), data(8)}
    localparam logic [11:0] VEC [NVEC] = '{
        {1'b0, 3'd1, 8'hA1}, {1'b0, 3'd3, 8'hB2}, {1'b0, 3'd1, 8'hC3},
        {1'b0, 3'd6, 8'h44}, {1'b0, 3'd1, 8'h55}, {1'b0, 3'd3, 8'h66},
        {1'b1, 3'd1, 8'h00}, {1'b1, 3'd3, 8'h00}, {1'b1, 3'd6, 8'h00},
        {1'b1, 3'd0, 8'h00}, {1'b1, 3'd7, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic ins_valid = 1'b0;
    logic [KW-1:0] ins_key = '0;
    logic [DW-1:0] ins_data = '0;
    logic qry_valid = 1'b0;
    logic [KW-1:0] qry_key = '0;
    logic qry_ready, out_valid, out_last, out_empty, overflow;
    logic [DW-1:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int mcnt [8];
    logic [DW-1:0] mdat [8][16];
    int mtot = 0;
    bit mpass2 = 1'b0;
    bit movf = 1'b0;

    always #2 clk = ~clk;

    keyed_bin_sorter #(.KEY_W(KW), .DATA_W(DW), .REC_DEPTH(DEPTH), .EPOCH_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ins_valid(ins_valid), .ins_key(ins_key), .ins_data(ins_data),
        .qry_valid(qry_valid), .qry_key(qry_key), .qry_ready(qry_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_empty(out_empty), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int k, input int d);
        @(negedge clk);
        ins_valid = 1'b1; ins_key = KW'(k); ins_data = DW'(d);
        @(posedge clk);
        if (!mpass2) begin
            if (mtot < DEPTH) begin
                mdat[k][mcnt[k]] = DW'(d);
                mcnt[k]++;
                mtot++;
            end else begin
                movf = 1'b1;
            end
        end
    endtask

    task automatic settle();
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) mcnt[i] = 0;
        mtot = 0; mpass2 = 1'b0; movf = 1'b0;
    endtask

    task automatic query_check(input int k, input string req);
        logic [DW-1:0] got [16];
        int n;
        bit emp, gap;
        @(negedge clk);
        qry_valid = 1'b1; qry_key = KW'(k);
        @(posedge clk);
        @(negedge clk);
        qry_valid = 1'b0;
        n = 0; emp = 1'b0; gap = 1'b0;
        for (int b = 0; b < 16; b++) begin
            if (!out_valid) begin gap = 1'b1; break; end
            chk(!qry_ready, "R9 ready during response", int'(qry_ready), 0);
            got[n] = out_data;
            n++;
            if (out_empty) emp = 1'b1;
            if (out_last) break;
            @(negedge clk);
        end
        chk(!gap, "R3 gapless stream", int'(gap), 0);
        if (mcnt[k] == 0) begin
            chk(emp && n == 1, "R4 empty response", n, 1);
        end else begin
            chk(!emp && n == mcnt[k], {req, " record count"}, n, mcnt[k]);
            for (int i = 0; i < n && i < mcnt[k]; i++) begin
                chk(got[i] == mdat[k][mcnt[k]-1-i], {req, " newest-first data"},
                    int'(got[i]), int'(mdat[k][mcnt[k]-1-i]));
            end
        end
        mpass2 = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mcnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(qry_ready == 1'b1, "R1 qry_ready", int'(qry_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

        // R2 vector walk: pushes then queries
        for (int v = 0; v < NVEC; v++) begin
            if (VEC[v][11]) begin
                settle();
                query_check(int'(VEC[v][10:8]), "R2");
            end else begin
                push(int'(VEC[v][10:8]), int'(VEC[v][7:0]));
            end
        end

        // R5 push in pass 2 is ignored
        push(0, 8'h77);
        push(1, 8'h78);
        settle();
        query_check(0, "R5");
        query_check(1, "R5");

        // R6 flush empties bins, new event works
        do_flush();
        chk(qry_ready == 1'b1, "R6 ready after flush", int'(qry_ready), 1);
        query_check(1, "R6");
        do_flush();
        push(2, 8'h11);
        settle();
        query_check(2, "R6");

        // R6 flush aborts a response in progress
        do_flush();
        push(4, 8'h01); push(4, 8'h02); push(4, 8'h03);
        settle();
        qry_valid = 1'b1; qry_key = 3'd4;
        @(posedge clk);
        @(negedge clk);
        qry_valid = 1'b0;
        chk(out_valid && out_data == 8'h03, "R6 first beat before abort", int'(out_data), 8'h03);
        flush = 1'b1;
        @(posedge clk);
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) mcnt[i] = 0;
        mtot = 0; mpass2 = 1'b0; movf = 1'b0;
        chk(!out_valid && qry_ready, "R6 abort", int'(out_valid), 0);
        query_check(4, "R6");

        // R7 overflow on a full store
        do_flush();
        for (int i = 0; i < DEPTH + 1; i++) push(5, 8'h80 + i);
        settle();
        chk(overflow == 1'b1 && movf, "R7 overflow set", int'(overflow), 1);
        query_check(5, "R7");
        chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);
        do_flush();
        chk(overflow == 1'b0, "R7 overflow cleared by flush", int'(overflow), 0);

        // R8 event counter wrap does not revive a stale bin
        push(2, 8'hAA);
        settle();
        do_flush();
        repeat (12) @(negedge clk);
        do_flush();
        do_flush();
        do_flush();
        query_check(2, "R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule